// File: doc/BRIEF.md
# Multi-Bank Concurrent Operation Tracker

This block sits beside the array control of a four-bank non-volatile memory. It records which bank owns a running program or erase, and which sector an erase targets. For every read address it decides, in the same cycle, whether the read may go to the array. A read to any bank that has no running operation proceeds with no added latency. A read to the bank that owns a running operation is refused, and the read path then returns status instead of array data.

An erase can be suspended. While it is suspended, its bank is open for reads and for one nested program everywhere except the sector under erase. A read that hits that sector raises a dedicated flag. Each bank is 2^20 words. Bank 0 has eight 8-Kword boot sectors at its bottom, bank 3 has eight at its top, and every other region is split into 32-Kword sectors. The bank and sector decode follows this asymmetric map.

The controller states are IDLE, PROG (program running), ERASE (erase running), ESUSP (erase suspended) and PSUSP (program running inside a suspended erase). The transitions are:
- IDLE to ERASE on an erase start. IDLE to PROG on a program start. An erase start wins when both arrive.
- PROG to IDLE on completion.
- ERASE to IDLE on completion. ERASE to ESUSP on a suspend request, where completion takes priority.
- ESUSP to ERASE on a resume request. ESUSP to PSUSP on a program start outside the erased sector.
- PSUSP to ESUSP on completion.

Top module: `bank_op_tracker`

## Requirements
- R1: After a synchronous active-low reset, no bank is busy, every read is permitted and the suspend-hit flag is low.
- R2: The bank is the two top address bits. A started operation marks its bank in busy_bank (bit b for bank b) from the next clock on, with at most one bit set.
- R3: A read whose bank bit in busy_bank is clear, and that does not hit a suspended erase sector, is permitted in the same cycle.
- R4: A read to the bank marked in busy_bank is refused in the same cycle.
- R5: Completion clears busy_bank at the next clock edge. In ERASE, completion takes priority over a suspend request arriving in the same cycle.
- R6: Suspending an erase clears busy_bank, and reads elsewhere in that bank are permitted.
- R7: While an erase is suspended, a read in the erased sector is refused and raises rd_susp_hit. Other reads leave rd_susp_hit low.
- R8: Sector size is 8 Kwords in bank offsets 0x00000-0x0FFFF of bank 0 and 0xF0000-0xFFFFF of bank 3, and 32 Kwords everywhere else.
- R9: While an erase is suspended, a program start outside the erased sector marks its bank busy until completion, which returns to the suspended erase. A program start inside the erased sector is ignored.
- R10: A resume request in ESUSP marks the erase bank busy again from the next clock.
- R11: While a program or an unsuspended erase runs, start requests are ignored, and a suspend request during a program is ignored.
- R12: When an erase start and a program start arrive together in IDLE, the erase is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_addr | input | 22 | Word address of the current read |
| op_addr | input | 22 | Target word address of a start request |
| start_prog | input | 1 | Program start request |
| start_erase | input | 1 | Sector erase start request |
| suspend_req | input | 1 | Erase suspend request |
| resume_req | input | 1 | Erase resume request |
| done | input | 1 | Embedded operation completed |
| busy_bank | output | 4 | One bit per bank with a running operation |
| rd_ok | output | 1 | Read may access the array |
| rd_susp_hit | output | 1 | Read targets the sector under suspended erase |

## Verification
Reads are swept across the busy bank, a neighbouring bank and both edges of the target sector. This separates a bank-level block from a sector-level block, and it catches an off-by-one in the bank field. Erases are placed in a low boot sector, in a high boot sector, in the 32-Kword sector just above and just below each boot region, and in a middle bank. Probing one word on each side of every sector boundary shows whether the decoder applies the 8-Kword or the 32-Kword size in each region. Collision patterns test the arbitration order: completion together with suspend, erase together with program, and a program aimed inside the suspended sector.

// File: rtl/bot_pkg.sv
package bot_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_ERASE,
        ST_ESUSP,
        ST_PSUSP
    } trk_state_e;

endpackage

// File: rtl/bot_addr_dec.sv
// Splits a word address into its bank and the base address of its sector.
module bot_addr_dec #(
    parameter int ADDR_W   = 22,
    parameter int BANK_W   = 2,
    parameter int BIG_W    = 15,
    parameter int BOOT_W   = 13,
    parameter int BOOT_CNT = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank,
    output logic [ADDR_W-1:0] sec_base,
    output logic              is_boot
);
    localparam int OFF_W = ADDR_W - BANK_W;
    localparam int REG_W = BOOT_W + $clog2(BOOT_CNT);
    localparam int HI_W  = OFF_W - REG_W;

    logic [HI_W-1:0] region;
    logic            low_boot;
    logic            high_boot;

    assign bank      = addr[ADDR_W-1 -: BANK_W];
    assign region    = addr[OFF_W-1:REG_W];
    assign low_boot  = (bank == '0) && (region == '0);
    assign high_boot = (bank == '1) && (region == '1);
    assign is_boot   = low_boot || high_boot;

    always_comb begin
        sec_base = addr;
        if (is_boot) begin
            sec_base[BOOT_W-1:0] = '0;
        end else begin
            sec_base[BIG_W-1:0] = '0;
        end
    end

endmodule

// File: rtl/bot_fsm.sv
// Operation state and the bank/sector owned by each operation.
module bot_fsm
    import bot_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_prog,
    input  logic              start_erase,
    input  logic              suspend_req,
    input  logic              resume_req,
    input  logic              done,
    input  logic [BANK_W-1:0] op_bank,
    input  logic [ADDR_W-1:0] op_sec,
    output trk_state_e        state,
    output logic [BANK_W-1:0] prog_bank,
    output logic [BANK_W-1:0] erase_bank,
    output logic [ADDR_W-1:0] erase_sec
);
    trk_state_e state_q;
    trk_state_e state_d;
    logic       cap_erase;
    logic       cap_prog;
    logic       outside_sec;

    assign outside_sec = (op_sec != erase_sec);

    always_comb begin
        state_d   = state_q;
        cap_erase = 1'b0;
        cap_prog  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_erase) begin
                    state_d   = ST_ERASE;
                    cap_erase = 1'b1;
                end else if (start_prog) begin
                    state_d  = ST_PROG;
                    cap_prog = 1'b1;
                end
            end
            ST_PROG: begin
                if (done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_ERASE: begin
                if (done) begin
                    state_d = ST_IDLE;
                end else if (suspend_req) begin
                    state_d = ST_ESUSP;
                end
            end
            ST_ESUSP: begin
                if (resume_req) begin
                    state_d = ST_ERASE;
                end else if (start_prog && outside_sec) begin
                    state_d  = ST_PSUSP;
                    cap_prog = 1'b1;
                end
            end
            ST_PSUSP: begin
                if (done) begin
                    state_d = ST_ESUSP;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_bank  <= '0;
            erase_bank <= '0;
            erase_sec  <= '0;
        end else begin
            if (cap_erase) begin
                erase_bank <= op_bank;
                erase_sec  <= op_sec;
            end
            if (cap_prog) begin
                prog_bank <= op_bank;
            end
        end
    end

    assign state = state_q;

endmodule

// File: rtl/bot_out.sv
// Read permission and busy indication from the operation state.
module bot_out
    import bot_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int BANK_W = 2
) (
    input  trk_state_e              state,
    input  logic [BANK_W-1:0]       prog_bank,
    input  logic [BANK_W-1:0]       erase_bank,
    input  logic [ADDR_W-1:0]       erase_sec,
    input  logic [BANK_W-1:0]       rd_bank,
    input  logic [ADDR_W-1:0]       rd_sec,
    output logic [(1<<BANK_W)-1:0]  busy_bank,
    output logic                    rd_ok,
    output logic                    rd_susp_hit
);
    localparam int BANKS = 1 << BANK_W;

    logic              run_valid;
    logic [BANK_W-1:0] run_bank;
    logic              suspended;

    always_comb begin
        run_valid = 1'b0;
        run_bank  = '0;
        suspended = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_PROG: begin
                run_valid = 1'b1;
                run_bank  = prog_bank;
            end
            ST_ERASE: begin
                run_valid = 1'b1;
                run_bank  = erase_bank;
            end
            ST_ESUSP: begin
                suspended = 1'b1;
            end
            ST_PSUSP: begin
                run_valid = 1'b1;
                run_bank  = prog_bank;
                suspended = 1'b1;
            end
            default: ;
        endcase
    end

    for (genvar g = 0; g < BANKS; g++) begin : g_busy
        assign busy_bank[g] = run_valid && (run_bank == BANK_W'(g));
    end

    assign rd_susp_hit = suspended && (rd_sec == erase_sec);
    assign rd_ok       = !busy_bank[rd_bank] && !rd_susp_hit;

endmodule

// File: rtl/bank_op_tracker.sv
module bank_op_tracker
    import bot_pkg::*;
#(
    parameter int ADDR_W   = 22,
    parameter int BANK_W   = 2,
    parameter int BIG_W    = 15,
    parameter int BOOT_W   = 13,
    parameter int BOOT_CNT = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      rd_addr,
    input  logic [ADDR_W-1:0]      op_addr,
    input  logic                   start_prog,
    input  logic                   start_erase,
    input  logic                   suspend_req,
    input  logic                   resume_req,
    input  logic                   done,
    output logic [(1<<BANK_W)-1:0] busy_bank,
    output logic                   rd_ok,
    output logic                   rd_susp_hit
);
    logic [BANK_W-1:0] rd_bank;
    logic [ADDR_W-1:0] rd_sec;
    logic              rd_boot;
    logic [BANK_W-1:0] op_bank;
    logic [ADDR_W-1:0] op_sec;
    logic              op_boot;
    trk_state_e        state;
    logic [BANK_W-1:0] prog_bank;
    logic [BANK_W-1:0] erase_bank;
    logic [ADDR_W-1:0] erase_sec;

    bot_addr_dec #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W), .BIG_W(BIG_W),
        .BOOT_W(BOOT_W), .BOOT_CNT(BOOT_CNT)
    ) u_rd_dec (
        .addr(rd_addr), .bank(rd_bank), .sec_base(rd_sec), .is_boot(rd_boot)
    );

    bot_addr_dec #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W), .BIG_W(BIG_W),
        .BOOT_W(BOOT_W), .BOOT_CNT(BOOT_CNT)
    ) u_op_dec (
        .addr(op_addr), .bank(op_bank), .sec_base(op_sec), .is_boot(op_boot)
    );

    bot_fsm #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start_prog(start_prog), .start_erase(start_erase),
        .suspend_req(suspend_req), .resume_req(resume_req), .done(done),
        .op_bank(op_bank), .op_sec(op_sec),
        .state(state), .prog_bank(prog_bank),
        .erase_bank(erase_bank), .erase_sec(erase_sec)
    );

    bot_out #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_out (
        .state(state), .prog_bank(prog_bank), .erase_bank(erase_bank),
        .erase_sec(erase_sec), .rd_bank(rd_bank), .rd_sec(rd_sec),
        .busy_bank(busy_bank), .rd_ok(rd_ok), .rd_susp_hit(rd_susp_hit)
    );

    logic unused_boot;
    assign unused_boot = rd_boot ^ op_boot;

endmodule

// File: rtl/bank_op_tracker_chk.sv
module bank_op_tracker_chk #(
    parameter int ADDR_W = 22,
    parameter int BANK_W = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      rd_addr,
    input logic                   suspend_req,
    input logic                   resume_req,
    input logic                   done,
    input logic [(1<<BANK_W)-1:0] busy_bank,
    input logic                   rd_ok,
    input logic                   rd_susp_hit
);
    logic [BANK_W-1:0] rb;
    assign rb = rd_addr[ADDR_W-1 -: BANK_W];

    p_onehot_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(busy_bank));

    p_free_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_bank[rb] && !rd_susp_hit) |-> rd_ok);

    p_busy_refused_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_bank[rb] |-> !rd_ok);

    p_done_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && busy_bank != '0) |=> (busy_bank == '0));

    p_hit_refused_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_susp_hit |-> !rd_ok);

    p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_bank != '0 && !done && !suspend_req && !resume_req) |=> $stable(busy_bank));

endmodule

bind bank_op_tracker bank_op_tracker_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .suspend_req(suspend_req),
    .resume_req(resume_req), .done(done), .busy_bank(busy_bank),
    .rd_ok(rd_ok), .rd_susp_hit(rd_susp_hit)
);

// File: tb/bank_op_tracker_tb.sv
module bank_op_tracker_tb;
    localparam int CLK_P = 10;
    localparam int WDOG  = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [21:0] rd_addr = '0;
    logic [21:0] op_addr = '0;
    logic        start_prog = 1'b0;
    logic        start_erase = 1'b0;
    logic        suspend_req = 1'b0;
    logic        resume_req = 1'b0;
    logic        done = 1'b0;
    logic [3:0]  busy_bank;
    logic        rd_ok;
    logic        rd_susp_hit;

    int    total = 0;
    int    bad = 0;
    int    cycles = 0;
    bit    armed = 0;
    string cur_req = "R1";

    // model: 0 idle, 1 prog, 2 erase, 3 erase suspended, 4 prog in suspend
    int m_st = 0;
    int m_pbank = 0;
    int m_ebank = 0;
    int m_esec = 0;

    always #(CLK_P/2) clk = ~clk;

    bank_op_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .op_addr(op_addr),
        .start_prog(start_prog), .start_erase(start_erase),
        .suspend_req(suspend_req), .resume_req(resume_req), .done(done),
        .busy_bank(busy_bank), .rd_ok(rd_ok), .rd_susp_hit(rd_susp_hit)
    );

    function automatic int sec_id(int a);
        int bank = a >> 20;
        int off  = a & 'hFFFFF;
        if ((bank == 0 && off < 'h10000) || (bank == 3 && off >= 'hF0000))
            return a >> 13;
        return (a >> 15) + 'h100000;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0;
        end else begin
            case (m_st)
                0: if (start_erase) begin
                       m_st = 2; m_ebank = int'(op_addr) >> 20; m_esec = sec_id(int'(op_addr));
                   end else if (start_prog) begin
                       m_st = 1; m_pbank = int'(op_addr) >> 20;
                   end
                1: if (done) m_st = 0;
                2: if (done) m_st = 0; else if (suspend_req) m_st = 3;
                3: if (resume_req) m_st = 2;
                   else if (start_prog && sec_id(int'(op_addr)) != m_esec) begin
                       m_st = 4; m_pbank = int'(op_addr) >> 20;
                   end
                4: if (done) m_st = 3;
                default: m_st = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (armed) begin
            logic [3:0] e_busy;
            logic       e_hit;
            logic       e_ok;
            int         rb;
            rb = int'(rd_addr) >> 20;
            e_busy = '0;
            if (m_st == 1 || m_st == 4) e_busy[m_pbank] = 1'b1;
            if (m_st == 2) e_busy[m_ebank] = 1'b1;
            e_hit = (m_st == 3 || m_st == 4) && (sec_id(int'(rd_addr)) == m_esec);
            e_ok  = !e_busy[rb] && !e_hit;
            total++;
            if (busy_bank !== e_busy || rd_ok !== e_ok || rd_susp_hit !== e_hit) begin
                bad++;
                $display("FAIL %s rd=%h busy=%b ok=%b hit=%b expected busy=%b ok=%b hit=%b",
                         cur_req, rd_addr, busy_bank, rd_ok, rd_susp_hit, e_busy, e_ok, e_hit);
            end
        end
        if (cycles > WDOG) begin
            total++;
            bad++;
            $display("FAIL %s watchdog expired", cur_req);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic cyc(int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic rd(int a, int n = 1);
        rd_addr = 22'(a);
        cyc(n);
    endtask

    task automatic go_erase(int a);
        op_addr = 22'(a); start_erase = 1'b1; cyc(1); start_erase = 1'b0;
    endtask

    task automatic go_prog(int a);
        op_addr = 22'(a); start_prog = 1'b1; cyc(1); start_prog = 1'b0;
    endtask

    task automatic fin();
        done = 1'b1; cyc(1); done = 1'b0;
    endtask

    task automatic susp();
        suspend_req = 1'b1; cyc(1); suspend_req = 1'b0;
    endtask

    task automatic resume();
        resume_req = 1'b1; cyc(1); resume_req = 1'b0;
    endtask

    // erase at ea, suspend, probe reads, resume and finish
    task automatic probe_sector(int ea, int in_lo, int in_hi, int out_lo, int out_hi);
        go_erase(ea);
        rd(ea);
        susp();
        rd(in_lo); rd(in_hi); rd(out_lo); rd(out_hi);
        resume();
        fin();
        rd(in_lo);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        armed = 1'b1;
        cur_req = "R1";
        rd('h000000); rd('h3FFFFF);

        cur_req = "R2";
        go_prog('h234567);
        cur_req = "R4";
        rd('h234567); rd('h200000); rd('h2FFFFF);
        cur_req = "R3";
        rd('h1FFFFF); rd('h300000); rd('h000000);
        cur_req = "R11";
        go_erase('h100000);
        susp();
        go_prog('h000000);
        rd('h200000);
        cur_req = "R5";
        fin();
        rd('h200000, 2);

        cur_req = "R6";
        go_erase('h104000);
        rd('h108000);
        susp();
        rd('h108000); rd('h0FFFFF);
        cur_req = "R7";
        rd('h107FFF); rd('h100000);
        done = 1'b1; cyc(1); done = 1'b0;
        rd('h100000);
        cur_req = "R10";
        resume();
        rd('h108000); rd('h104000);
        cur_req = "R9";
        susp();
        go_prog('h107000);
        rd('h110000); rd('h104000);
        go_prog('h310000);
        rd('h310000); rd('h100000); rd('h110000);
        go_erase('h200000);
        resume();
        rd('h300000);
        fin();
        rd('h100000); rd('h310000);
        resume();
        cur_req = "R5";
        done = 1'b1; suspend_req = 1'b1; cyc(1); done = 1'b0; suspend_req = 1'b0;
        rd('h100000, 2);

        cur_req = "R8";
        probe_sector('h001000, 'h000000, 'h001FFF, 'h002000, 'h00FFFF);
        probe_sector('h00E000, 'h00E000, 'h00FFFF, 'h00DFFF, 'h010000);
        probe_sector('h010000, 'h010000, 'h017FFF, 'h00FFFF, 'h018000);
        probe_sector('h3F1234, 'h3F0000, 'h3F1FFF, 'h3EFFFF, 'h3F2000);
        probe_sector('h3E9000, 'h3E8000, 'h3EFFFF, 'h3E7FFF, 'h3F0000);
        probe_sector('h3FFFFF, 'h3FE000, 'h3FFFFF, 'h3FDFFF, 'h2FFFFF);
        probe_sector('h1F8000, 'h1F8000, 'h1FFFFF, 'h1F7FFF, 'h200000);

        cur_req = "R12";
        op_addr = 22'h220000; start_erase = 1'b1; start_prog = 1'b1;
        cyc(1);
        start_erase = 1'b0; start_prog = 1'b0;
        rd('h220000);
        susp();
        rd('h220000); rd('h228000);
        resume();
        fin();
        rd('h220000);

        cur_req = "R11";
        go_prog('h010000);
        susp();
        rd('h020000, 2);
        fin();

        cur_req = "R1";
        rst_n = 1'b0;
        go_prog('h300000);
        armed = 1'b0;
        cyc(1);
        rst_n = 1'b1;
        armed = 1'b1;
        rd('h300000, 2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule